// File: doc/BRIEF.md
# Dual-Rail Channel Codec

This block is a clocked model of a four-phase, delay-insensitive channel. Every data bit travels on two wires. The transmit half takes an n-bit single-rail word offered with a valid/ready handshake. It drives the matching dual-rail codeword onto its rail outputs and holds it until the far side acknowledges. It then returns every wire pair to the empty (spacer) state and waits for the acknowledge to be released before it accepts the next word.

The receive half needs no valid strobe. It treats a bit as present as soon as either of its wires is high. The per-bit presence flags are joined through a tree of two-input C-elements, each of which keeps its state until its inputs agree. The root of that tree is registered as the acknowledge. The acknowledge therefore rises only after every bit is present and falls only after every bit has gone back to empty. On the rising edge of the acknowledge the receiver captures the decoded word and pulses a strobe. A separate flag reports any pair that has both wires high. The two halves are independent, so they can face each other across a link or be looped back.

Top module: `dr_channel_codec`

## Requirements
- R1: Each word bit k owns the pair tx_rail_one[k] / tx_rail_zero[k] (2*WIDTH wires in all). A data 1 drives only tx_rail_one[k] high, and a data 0 drives only tx_rail_zero[k] high. The codeword appears on the rails one clock after the word is accepted.
- R2: While reset is held, and after it is released, all transmit rails are low (spacer), tx_ready is high (with tx_ack low), and rx_ack, rx_strobe and rx_error are low.
- R3: The transmitter holds a codeword unchanged on its rails while tx_ack is low. In the clock after it samples tx_ack high, it drives every rail low.
- R4: A word is accepted only on a clock where tx_valid and tx_ready are both high. tx_ready is low while a codeword or spacer phase is in progress and whenever tx_ack is high, so a new codeword never follows a spacer until tx_ack has dropped. A tx_valid offered during that time leaves the rails at spacer.
- R5: rx_ack rises one clock after the first clock in which every receive pair has at least one wire high.
- R6: rx_ack keeps its value while only some pairs are present. It falls one clock after the first clock in which every receive pair is back to both-low.
- R7: rx_data takes the rx_rail_one wires in the clock in which rx_ack rises, and holds that value until the next rise. rx_strobe is high for exactly that one clock.
- R8: rx_error is high one clock after any receive pair has both wires high, and low one clock after no pair does.
- R9: With transmit rails fed to receive rails and rx_ack fed back to tx_ack, every accepted word is delivered once, in order and unchanged, and rx_error stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_valid | input | 1 | A word is offered on tx_data |
| tx_data | input | WIDTH | Single-rail word to send |
| tx_ready | output | 1 | Transmitter can take a word this clock |
| tx_rail_one | output | WIDTH | Transmit wires that signal a 1 |
| tx_rail_zero | output | WIDTH | Transmit wires that signal a 0 |
| tx_ack | input | 1 | Acknowledge returned by the receiving side |
| rx_rail_one | input | WIDTH | Receive wires that signal a 1 |
| rx_rail_zero | input | WIDTH | Receive wires that signal a 0 |
| rx_ack | output | 1 | Completion acknowledge (all present / all empty) |
| rx_data | output | WIDTH | Last decoded word |
| rx_strobe | output | 1 | One-clock pulse when rx_data is loaded |
| rx_error | output | 1 | Some receive pair has both wires high |

## Verification
A C-element that wrongly clears or sets would show up at rx_ack while the rails are only partly present or partly empty. The acknowledge would then move one clock after a partial pattern instead of waiting for the full word or the full spacer. A transmitter state error shows up either as a codeword that changes while acknowledge is low, or as rails that stay valid one clock after acknowledge. An early reissue shows up as a codeword appearing while acknowledge is still high. Each of these faults is visible at the ports within one or two clocks of the stimulus that exposes it. In looped-back operation, any decode or ordering fault corrupts the next delivered word.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef enum logic [1:0] {
    TX_IDLE = 2'd0,
    TX_DATA = 2'd1,
    TX_RTZ  = 2'd2
  } tx_state_e;
endpackage

// File: rtl/dr_celem.sv
// Two-input C-element with hysteresis held in a register.
module dr_celem (
  input  logic clk,
  input  logic rst_n,
  input  logic in_a,
  input  logic in_b,
  output logic out
);
  logic state_q;
  logic both_hi, both_lo;

  assign both_hi = in_a & in_b;
  assign both_lo = ~in_a & ~in_b;
  assign out     = both_hi | (state_q & ~both_lo);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= 1'b0;
    else        state_q <= out;
  end
endmodule

// File: rtl/dr_ctree.sv
// Joins N presence flags through a binary tree of C-elements.
module dr_ctree #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] leaf,
  output logic         root
);
  localparam int LEVELS = (N > 1) ? $clog2(N) : 1;
  localparam int P      = 1 << LEVELS;

  logic [2*P-1:1] node;

  genvar k;
  generate
    for (k = 0; k < P; k++) begin : g_leaf
      if (k < N) begin : g_real
        assign node[P+k] = leaf[k];
      end else begin : g_pad
        assign node[P+k] = leaf[0];
      end
    end
    for (k = 1; k < P; k++) begin : g_node
      logic c_out;
      dr_celem u_c (
        .clk  (clk),
        .rst_n(rst_n),
        .in_a (node[2*k]),
        .in_b (node[2*k+1]),
        .out  (c_out)
      );
      assign node[k] = c_out;
    end
  endgenerate

  assign root = node[1];
endmodule

// File: rtl/dr_encoder.sv
module dr_encoder
  import dr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid,
  input  logic [WIDTH-1:0] tx_data,
  output logic             tx_ready,
  input  logic             tx_ack,
  output logic [WIDTH-1:0] rail_one,
  output logic [WIDTH-1:0] rail_zero
);
  tx_state_e        state_q, state_d;
  logic [WIDTH-1:0] one_q, one_d, zero_q, zero_d;
  logic             rail_en;

  assign tx_ready = (state_q == TX_IDLE) & ~tx_ack;

  always_comb begin
    state_d = state_q;
    one_d   = one_q;
    zero_d  = zero_q;
    rail_en = 1'b0;
    case (state_q)
      TX_IDLE: begin
        if (tx_valid && !tx_ack) begin
          state_d = TX_DATA;
          one_d   = tx_data;
          zero_d  = ~tx_data;
          rail_en = 1'b1;
        end
      end
      TX_DATA: begin
        if (tx_ack) begin
          state_d = TX_RTZ;
          one_d   = '0;
          zero_d  = '0;
          rail_en = 1'b1;
        end
      end
      TX_RTZ: begin
        if (!tx_ack) state_d = TX_IDLE;
      end
      default: begin
        state_d = TX_IDLE;
        one_d   = '0;
        zero_d  = '0;
        rail_en = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TX_IDLE;
      one_q   <= '0;
      zero_q  <= '0;
    end else begin
      state_q <= state_d;
      if (rail_en) begin
        one_q  <= one_d;
        zero_q <= zero_d;
      end
    end
  end

  assign rail_one  = one_q;
  assign rail_zero = zero_q;
endmodule

// File: rtl/dr_receiver.sv
module dr_receiver #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] rail_one,
  input  logic [WIDTH-1:0] rail_zero,
  output logic             ack,
  output logic [WIDTH-1:0] data,
  output logic             strobe,
  output logic             error
);
  logic [WIDTH-1:0] present;
  logic             complete;
  logic             ack_q, ack_d;
  logic [WIDTH-1:0] data_q;
  logic             strobe_q, strobe_d;
  logic             err_q, err_d;
  logic             cap_en;

  assign present = rail_one | rail_zero;

  dr_ctree #(.N(WIDTH)) u_tree (
    .clk  (clk),
    .rst_n(rst_n),
    .leaf (present),
    .root (complete)
  );

  always_comb begin
    ack_d    = complete;
    cap_en   = complete & ~ack_q;
    strobe_d = cap_en;
    err_d    = |(rail_one & rail_zero);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      strobe_q <= 1'b0;
      err_q    <= 1'b0;
      data_q   <= '0;
    end else begin
      ack_q    <= ack_d;
      strobe_q <= strobe_d;
      err_q    <= err_d;
      if (cap_en) data_q <= rail_one;
    end
  end

  assign ack    = ack_q;
  assign data   = data_q;
  assign strobe = strobe_q;
  assign error  = err_q;
endmodule

// File: rtl/dr_channel_codec.sv
module dr_channel_codec #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid,
  input  logic [WIDTH-1:0] tx_data,
  output logic             tx_ready,
  output logic [WIDTH-1:0] tx_rail_one,
  output logic [WIDTH-1:0] tx_rail_zero,
  input  logic             tx_ack,
  input  logic [WIDTH-1:0] rx_rail_one,
  input  logic [WIDTH-1:0] rx_rail_zero,
  output logic             rx_ack,
  output logic [WIDTH-1:0] rx_data,
  output logic             rx_strobe,
  output logic             rx_error
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  dr_encoder #(.WIDTH(WIDTH)) u_enc (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tx_valid (tx_valid),
    .tx_data  (tx_data),
    .tx_ready (tx_ready),
    .tx_ack   (tx_ack),
    .rail_one (tx_rail_one),
    .rail_zero(tx_rail_zero)
  );

  dr_receiver #(.WIDTH(WIDTH)) u_rcv (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .rail_one (rx_rail_one),
    .rail_zero(rx_rail_zero),
    .ack      (rx_ack),
    .data     (rx_data),
    .strobe   (rx_strobe),
    .error    (rx_error)
  );
endmodule

// File: rtl/dr_channel_codec_chk.sv
module dr_channel_codec_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] tx_rail_one,
  input logic [WIDTH-1:0] tx_rail_zero,
  input logic             tx_ack,
  input logic [WIDTH-1:0] rx_rail_one,
  input logic [WIDTH-1:0] rx_rail_zero,
  input logic             rx_ack,
  input logic             rx_strobe,
  input logic             rx_error
);
  logic tx_busy, rx_full, rx_empty, rx_clash;
  assign tx_busy  = |(tx_rail_one | tx_rail_zero);
  assign rx_full  = &(rx_rail_one | rx_rail_zero);
  assign rx_empty = ~|(rx_rail_one | rx_rail_zero);
  assign rx_clash = |(rx_rail_one & rx_rail_zero);

  // R1
  tx_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_busy |-> &(tx_rail_one ^ tx_rail_zero));

  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && !tx_ack) |=> ($stable(tx_rail_one) && $stable(tx_rail_zero)));

  // R3
  tx_rtz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && tx_ack) |=> !tx_busy);

  // R4
  tx_no_reissue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_busy && tx_ack) |=> !tx_busy);

  // R5
  rx_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ack) |-> $past(rx_full));

  // R6
  rx_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ack) |-> $past(rx_empty));

  // R7
  rx_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> $rose(rx_ack));

  // R8
  rx_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clash |=> rx_error);

  // R8
  rx_err_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_clash |=> !rx_error);
endmodule

bind dr_channel_codec dr_channel_codec_chk #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .tx_rail_one (tx_rail_one),
  .tx_rail_zero(tx_rail_zero),
  .tx_ack      (tx_ack),
  .rx_rail_one (rx_rail_one),
  .rx_rail_zero(rx_rail_zero),
  .rx_ack      (rx_ack),
  .rx_strobe   (rx_strobe),
  .rx_error    (rx_error)
);

// File: tb/dr_channel_codec_test.sv
module dr_channel_codec_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tx_valid = 1'b0;
  logic [W-1:0] tx_data = '0;
  logic         tx_ready;
  logic [W-1:0] tx_rail_one, tx_rail_zero;
  logic         tx_ack;
  logic [W-1:0] rx_rail_one, rx_rail_zero;
  logic         rx_ack;
  logic [W-1:0] rx_data;
  logic         rx_strobe, rx_error;

  logic         loop = 1'b0;
  logic         drv_ack = 1'b0;
  logic [W-1:0] drv_one = '0, drv_zero = '0;

  int checks = 0;
  int errors = 0;
  int delivered = 0;
  logic [W-1:0] expq[$];

  always #10 clk = ~clk;

  assign rx_rail_one  = loop ? tx_rail_one  : drv_one;
  assign rx_rail_zero = loop ? tx_rail_zero : drv_zero;
  assign tx_ack       = loop ? rx_ack       : drv_ack;

  dr_channel_codec #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .tx_rail_one(tx_rail_one), .tx_rail_zero(tx_rail_zero), .tx_ack(tx_ack),
    .rx_rail_one(rx_rail_one), .rx_rail_zero(rx_rail_zero),
    .rx_ack(rx_ack), .rx_data(rx_data), .rx_strobe(rx_strobe), .rx_error(rx_error)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // driver: offers a word and pushes its expected delivery
  task automatic send_word(input logic [W-1:0] w);
    tx_data  = w;
    tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    expq.push_back(w);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // monitor: pops and compares on every delivery in loopback
  always @(negedge clk) begin
    if (rst_n && loop && rx_strobe) begin
      delivered++;
      if (expq.size() == 0) chk("R9 unexpected word", {24'd0, rx_data}, 32'hDEAD);
      else chk("R9 delivered word", {24'd0, rx_data}, {24'd0, expq.pop_front()});
      chk("R9 no error in loop", {31'd0, rx_error}, 32'd0);
    end
  end

  initial begin
    cyc(3);
    chk("R2 rails spacer in reset", {16'd0, tx_rail_one, tx_rail_zero}, 32'd0);
    rst_n = 1'b1;
    cyc(4);
    chk("R2 rails spacer after reset", {16'd0, tx_rail_one, tx_rail_zero}, 32'd0);
    chk("R2 ready after reset", {31'd0, tx_ready}, 32'd1);
    chk("R2 rx idle after reset", {29'd0, rx_ack, rx_strobe, rx_error}, 32'd0);

    // receiver: partial presence keeps ack low (R6 hysteresis)
    drv_one = 8'h05; drv_zero = 8'h30;
    cyc(3);
    chk("R6 partial word no ack", {31'd0, rx_ack}, 32'd0);
    drv_one = 8'hA5; drv_zero = 8'h5A;
    cyc(1);
    chk("R5 ack one clock after full", {31'd0, rx_ack}, 32'd1);
    chk("R7 strobe on ack rise", {31'd0, rx_strobe}, 32'd1);
    chk("R7 data captured", {24'd0, rx_data}, 32'h000000A5);
    cyc(1);
    chk("R7 strobe single clock", {31'd0, rx_strobe}, 32'd0);
    drv_one = 8'h01; drv_zero = 8'h00;
    cyc(3);
    chk("R6 partial spacer holds ack", {31'd0, rx_ack}, 32'd1);
    chk("R7 data held", {24'd0, rx_data}, 32'h000000A5);
    drv_one = 8'h00;
    cyc(1);
    chk("R6 ack falls after spacer", {31'd0, rx_ack}, 32'd0);

    // illegal pair
    drv_one = 8'h10; drv_zero = 8'h10;
    cyc(1);
    chk("R8 error on both-high pair", {31'd0, rx_error}, 32'd1);
    drv_one = 8'h00; drv_zero = 8'h00;
    cyc(1);
    chk("R8 error clears", {31'd0, rx_error}, 32'd0);

    // transmitter under manual acknowledge
    tx_data = 8'h3C; tx_valid = 1'b1;
    cyc(1);
    tx_valid = 1'b0;
    chk("R1 one rails", {24'd0, tx_rail_one}, 32'h0000003C);
    chk("R1 zero rails", {24'd0, tx_rail_zero}, 32'h000000C3);
    chk("R4 busy not ready", {31'd0, tx_ready}, 32'd0);
    tx_data = 8'hFF; tx_valid = 1'b1;
    cyc(3);
    chk("R3 codeword held", {16'd0, tx_rail_one, tx_rail_zero}, 32'h00003CC3);
    drv_ack = 1'b1;
    cyc(1);
    chk("R3 spacer after ack", {16'd0, tx_rail_one, tx_rail_zero}, 32'd0);
    cyc(3);
    chk("R4 no reissue while ack", {16'd0, tx_rail_one, tx_rail_zero}, 32'd0);
    chk("R4 not ready while ack", {31'd0, tx_ready}, 32'd0);
    tx_valid = 1'b0; drv_ack = 1'b0;
    cyc(1);
    chk("R4 ready after ack drops", {31'd0, tx_ready}, 32'd1);
    chk("R4 still spacer", {16'd0, tx_rail_one, tx_rail_zero}, 32'd0);

    // loopback scoreboard
    loop = 1'b1;
    cyc(2);
    send_word(8'h00);
    send_word(8'hFF);
    send_word(8'h81);
    send_word(8'h5A);
    for (int i = 0; i < 12; i++) send_word(W'((i * 37 + 11) & 8'hFF));
    cyc(20);
    chk("R9 all words delivered", delivered, 32'd16);
    chk("R9 queue drained", expq.size(), 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule